// File: doc/BRIEF.md
# Double-Buffered 16-bit Pulse Generator

This block produces a repeating rectangular waveform whose period and high (or low) time are each set as a 16-bit count. A CPU writes four byte-wide registers over a simple write port: two bytes form the period compare value and two bytes form the duty compare value. Writing the upper duty byte is the commit event. All four bytes then take effect together, so no partially updated compare pair is ever seen.

When running, a 16-bit up counter advances once per count tick. The tick comes either from an internal clock enable or from a synchronised rising edge of an external clock pin. When the counter reaches the duty value, the output flips away from its programmable starting level and a duty interrupt pulses. When it reaches the period value, the output returns to the starting level, a period interrupt pulses and the counter restarts from zero.

An optional buffer stage holds committed values. They move into the active compare registers at the next period match or when the run control rises, so the waveform changes only on a cycle boundary.

Top module: `pulse_gen16`

## Requirements
- R1: Byte register addresses are 0 = period low byte, 1 = period high byte, 2 = duty low byte and 3 = duty high byte. Period = {byte1, byte0} and duty = {byte3, byte2}.
- R2: A write to address 3 commits the period and duty pair together, using the stored bytes from addresses 0 to 2 and the written duty high byte.
- R3: Writes to addresses 0, 1 or 2 alone leave the compare values in use unchanged.
- R4: While run is 0, pulse_out equals init_level. Dropping run clears the counter to 0 and restores the starting level at once. After reset, pulse_out equals init_level and both interrupts are 0.
- R5: While run is 1, the counter starts at 0 and advances once per tick. With ext_sel = 0 the tick is tick_int. With ext_sel = 1 the tick is each rising edge of ext_clk after a two-flop synchroniser, and tick_int is then ignored.
- R6: On a tick with counter equal to the duty value (and not equal to the period value), pulse_out becomes the inverse of init_level and irq_duty pulses in the cycle after that tick.
- R7: On a tick with counter equal to the period value, pulse_out returns to init_level, irq_period pulses, and the counter clears to 0. One waveform cycle is therefore period + 1 ticks.
- R8: With dbuf_en = 1, a commit loads a buffer. The buffer moves to the active values at the next period match, or on the first tick-cycle after run rises, and the first compare after run rises already uses the buffered values.
- R9: If duty is greater than or equal to period, no duty match happens. pulse_out stays at init_level and only irq_period fires.
- R10: irq_duty and irq_period are one-cycle pulses, never high together, and only follow a cycle with run = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte register write strobe |
| wr_addr | input | 2 | Byte register address (R1 map) |
| wr_data | input | BYTE_W | Byte write data |
| run | input | 1 | Run control |
| init_level | input | 1 | Output level while stopped and at cycle start |
| dbuf_en | input | 1 | Route commits through the buffer stage |
| ext_sel | input | 1 | 1 selects external clock edges as the tick |
| tick_int | input | 1 | Internal count enable |
| ext_clk | input | 1 | External count clock, asynchronous |
| pulse_out | output | 1 | Pulse output |
| irq_duty | output | 1 | Duty-match interrupt pulse |
| irq_period | output | 1 | Period-match interrupt pulse |

## Verification
The bench builds the block with its defaults: an 8-bit byte width, so the counter is 16 bits, and a two-stage synchroniser. With these values, a period above 255 exercises the high byte within a few hundred cycles, and a duty of 0 or a duty at or above the period reaches the corner cases of R6 and R9. The short synchroniser keeps the external-clock test to a countable number of edges, and that test holds tick_int high to show it is ignored.

// File: rtl/pulse_gen16.sv
module pulse_gen16 #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              run,
  input  logic              init_level,
  input  logic              dbuf_en,
  input  logic              ext_sel,
  input  logic              tick_int,
  input  logic              ext_clk,
  output logic              pulse_out,
  output logic              irq_duty,
  output logic              irq_period
);
  localparam int CNT_W = 2 * BYTE_W;
  localparam logic [CNT_W-1:0] ONE = 1;

  logic [BYTE_W-1:0] per_lo, per_hi, dty_lo;
  logic [CNT_W-1:0]  per_buf, dty_buf, per_act, dty_act, cnt;
  logic [CNT_W-1:0]  per_cmp, dty_cmp, per_new, dty_new;
  logic [SYNC_STAGES:0] ext_sh;
  logic pend, run_q, phase;
  logic commit, start, tick, hit_p, hit_d, load_now, xfer;

  assign commit   = wr_en && (wr_addr == 2'd3);
  assign per_new  = {per_hi, per_lo};
  assign dty_new  = {wr_data, dty_lo};
  assign start    = run && !run_q;
  assign tick     = ext_sel ? (ext_sh[SYNC_STAGES-1] && !ext_sh[SYNC_STAGES]) : tick_int;
  assign load_now = dbuf_en && pend && start;
  assign per_cmp  = load_now ? per_buf : per_act;
  assign dty_cmp  = load_now ? dty_buf : dty_act;
  assign hit_p    = run && tick && (cnt == per_cmp);
  assign hit_d    = run && tick && (cnt == dty_cmp) && !hit_p;
  assign xfer     = dbuf_en && pend && (start || hit_p);
  assign pulse_out = init_level ^ (run && phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_sh <= '0;
    else        ext_sh <= {ext_sh[SYNC_STAGES-1:0], ext_clk};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_lo <= '0;
      per_hi <= '0;
      dty_lo <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0:    per_lo <= wr_data;
        2'd1:    per_hi <= wr_data;
        2'd2:    dty_lo <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_buf <= '0;
      dty_buf <= '0;
      pend    <= 1'b0;
    end else if (commit && dbuf_en) begin
      per_buf <= per_new;
      dty_buf <= dty_new;
      pend    <= 1'b1;
    end else if (xfer) begin
      pend    <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_act <= '0;
      dty_act <= '0;
    end else if (commit && !dbuf_en) begin
      per_act <= per_new;
      dty_act <= dty_new;
    end else if (xfer) begin
      per_act <= per_buf;
      dty_act <= dty_buf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      cnt        <= '0;
      phase      <= 1'b0;
      irq_duty   <= 1'b0;
      irq_period <= 1'b0;
    end else begin
      run_q      <= run;
      irq_duty   <= hit_d;
      irq_period <= hit_p;
      if (!run) begin
        cnt   <= '0;
        phase <= 1'b0;
      end else if (tick) begin
        if (hit_p) begin
          cnt   <= '0;
          phase <= 1'b0;
        end else begin
          cnt <= cnt + ONE;
          if (hit_d) phase <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pulse_gen16_chk.sv
module pulse_gen16_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             init_level,
  input logic             dbuf_en,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic             irq_duty,
  input logic             irq_period,
  input logic             pulse_out,
  input logic [CNT_W-1:0] per_act,
  input logic [CNT_W-1:0] dty_act
);
  AST_STOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> pulse_out == init_level); // R4
  AST_DUTY_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_duty && run) |-> pulse_out != init_level); // R6
  AST_PERIOD_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_period |-> pulse_out == init_level); // R7
  AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_duty, irq_period})); // R10
  AST_IRQ_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_duty || irq_period) |-> $past(run)); // R10
  AST_LOW_BYTES_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != 2'd3 && !dbuf_en) |=> ($stable(per_act) && $stable(dty_act))); // R3
endmodule

bind pulse_gen16 pulse_gen16_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .init_level(init_level),
  .dbuf_en(dbuf_en), .wr_en(wr_en), .wr_addr(wr_addr),
  .irq_duty(irq_duty), .irq_period(irq_period), .pulse_out(pulse_out),
  .per_act(per_act), .dty_act(dty_act)
);

// File: tb/test_pulse_gen16.sv
`timescale 1ns/1ps
module test_pulse_gen16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic run = 1'b0, init_level = 1'b0, dbuf_en = 1'b0, ext_sel = 1'b0;
  logic tick_int = 1'b1, ext_clk = 1'b0;
  logic pulse_out, irq_duty, irq_period;

  pulse_gen16 i_pulse_gen16 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .run(run), .init_level(init_level), .dbuf_en(dbuf_en), .ext_sel(ext_sel),
    .tick_int(tick_int), .ext_clk(ext_clk), .pulse_out(pulse_out),
    .irq_duty(irq_duty), .irq_period(irq_period)
  );

  always #4 clk = ~clk;

  typedef struct { bit kind; int cyc; bit lvl; string tag; } ev_t;
  ev_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  int n_duty = 0, n_per = 0, bad_lvl = 0;
  bit qmode = 1'b1, watch_init = 1'b0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (watch_init && run && pulse_out != init_level) bad_lvl++;
      if (irq_duty || irq_period) begin
        if (!qmode) begin
          if (irq_duty) n_duty++;
          if (irq_period) n_per++;
        end else if (q.size() == 0) begin
          chk(1'b0, "R10 unexpected interrupt", cyc, -1);
        end else begin
          ev_t e;
          e = q.pop_front();
          chk(irq_period == e.kind && irq_duty != e.kind, {e.tag, " kind"}, int'(irq_period), int'(e.kind));
          chk(cyc == e.cyc, {e.tag, " cycle"}, cyc, e.cyc);
          chk(pulse_out == e.lvl, {e.tag, " level"}, int'(pulse_out), int'(e.lvl));
        end
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d[7:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(input int p, input int d);
    wr(0, p & 255); wr(1, p >> 8); wr(2, d & 255); wr(3, d >> 8);
  endtask

  task automatic start_run(output int s);
    @(negedge clk);
    run = 1'b1;
    s = cyc + 1;
  endtask

  task automatic push_cycle(input int base, input int p, input int d, input string tag);
    if (d < p) q.push_back('{1'b0, base + d, ~init_level, {tag, " duty"}});
    q.push_back('{1'b1, base + p, init_level, {tag, " period"}});
  endtask

  task automatic stop_at(input int c);
    while (cyc < c) @(negedge clk);
    run = 1'b0;
  endtask

  task automatic simple(input int p, input int d, input int n, input string tag);
    int s;
    start_run(s);
    for (int k = 0; k < n; k++) push_cycle(s + k * (p + 1), p, d, tag);
    stop_at(s + n * (p + 1) - 1);
    repeat (2) @(negedge clk);
    chk(q.size() == 0, {tag, " all events seen"}, q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int s;
    repeat (3) @(negedge clk);
    chk(pulse_out == 1'b0 && !irq_duty && !irq_period, "R4 reset state", int'(pulse_out), 0);
    rst_n = 1'b1;
    @(negedge clk);

    load(10, 3);
    simple(10, 3, 3, "R1 R5 R6 R7 basic");

    init_level = 1'b1;
    @(negedge clk);
    chk(pulse_out == 1'b1, "R4 stopped level high", int'(pulse_out), 1);
    load(16'h0105, 16'h0102);
    simple(16'h0105, 16'h0102, 2, "R1 high bytes init1");
    init_level = 1'b0;

    load(4, 0);
    simple(4, 0, 3, "R6 duty zero");

    watch_init = 1'b1;
    load(6, 6);
    simple(6, 6, 2, "R9 duty equals period");
    load(6, 9);
    simple(6, 9, 2, "R9 duty above period");
    watch_init = 1'b0;
    chk(bad_lvl == 0, "R9 output held at start level", bad_lvl, 0);

    load(8, 2);
    wr(0, 3); wr(1, 0); wr(2, 1);
    simple(8, 2, 2, "R3 partial bytes ignored");
    wr(3, 0);
    simple(3, 1, 3, "R2 commit takes all four");

    load(20, 2);
    start_run(s);
    push_cycle(s, 20, 2, "R4 stop mid pulse");
    void'(q.pop_back());
    while (cyc < s + 3) @(negedge clk);
    chk(pulse_out == 1'b1, "R6 high after duty", int'(pulse_out), 1);
    run = 1'b0;
    #1;
    chk(pulse_out == 1'b0, "R4 stop restores level", int'(pulse_out), 0);
    repeat (2) @(negedge clk);
    simple(20, 2, 1, "R4 counter restarts from zero");

    dbuf_en = 1'b1;
    load(30, 4);
    start_run(s);
    push_cycle(s, 30, 4, "R8 buffered at run rise");
    push_cycle(s + 31, 6, 1, "R8 swap at period match");
    push_cycle(s + 38, 6, 1, "R8 second new cycle");
    load(6, 1);
    stop_at(s + 44);
    repeat (2) @(negedge clk);
    chk(q.size() == 0, "R8 all events seen", q.size(), 0);
    dbuf_en = 1'b0;

    load(3, 1);
    qmode = 1'b0;
    ext_sel = 1'b1;
    tick_int = 1'b1;
    @(negedge clk);
    run = 1'b1;
    for (int k = 0; k < 12; k++) begin
      ext_clk = 1'b1; repeat (4) @(negedge clk);
      ext_clk = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    run = 1'b0;
    chk(n_per == 3, "R5 external edges period count", n_per, 3);
    chk(n_duty == 3, "R5 external edges duty count", n_duty, 3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule